// File: doc/BRIEF.md
# Static Memory Bank Access Sequencer

This block runs one access at a time against asynchronous static devices (SRAM, ROM, NOR flash) hung off a shared external bus with one chip select per bank. A host presents a request (direction, bank number, address, write data and byte mask) and holds it until the sequencer answers with a one-cycle `done`. The sequencer then generates chip select, output enable, write enable, byte-lane strobes and the data-bus drive enable. Every bank has its own timing: strobe delays, access lengths and bus turnaround.

The controller is a Moore state machine with seven states. `ST_IDLE` waits for a request. `ST_TURN` holds the bus quiet between a read and a conflicting next access. `ST_RSETUP` has chip select low and output enable high. `ST_RACT` has output enable low. `ST_WSETUP` has chip select low and write enable high. `ST_WACT` has write enable low. `ST_WEND` releases write enable one cycle ahead of chip select.

The transitions are as follows. IDLE goes to TURN when a turnaround is owed. Otherwise it starts the access: writes enter WSETUP, reads with a nonzero output-enable delay enter RSETUP, and other reads enter RACT. TURN starts the access in the same way once its count expires. RSETUP goes to RACT. RACT goes to IDLE. WSETUP goes to WACT. WACT goes to WEND. WEND goes to IDLE. Each timed state leaves when its down-counter reaches zero.

Top module: `stmem_seq`

## Requirements
- R1: After reset, all chip selects, output enable, write enable and byte-lane strobes are high (inactive), the data-bus enable `mem_dq_oe` is low and `done` is low.
- R2: During an access exactly one chip select is low: `mem_cs_n[b]`, where b is the request's `req_bank`. No chip select is low otherwise.
- R3: For a read to bank b, let D be the 4-bit output-enable delay field and W the 5-bit read-wait field. Chip select stays low for D+W+1 cycles. Output enable falls D cycles after chip select and rises in the same cycle as chip select.
- R4: `done` is high for exactly one cycle per access. For a read, that cycle is the last cycle of output enable, and `rdata` then equals `mem_dq_in`.
- R5: For a write to bank b, let D be the 4-bit write-enable delay field and W the 5-bit write-wait field. Write enable falls D+1 cycles after chip select, stays low for W+1 cycles, and rises one cycle before chip select. Chip select is low for D+W+3 cycles.
- R6: Byte-lane strobe `mem_bls_n[i]` (lane i = data bits 8i+7:8i) is low exactly in the cycles where write enable is low and `req_be[i]` was 1. All lanes stay high during reads.
- R7: `mem_dq_oe` is high during every chip-select-low cycle of a write and low at all other times, so it is never high while output enable is low.
- R8: When a read is followed by a read to a different bank, or by a write to any bank, chip select stays high for T+1 cycles after the next request is accepted. T is the 4-bit turnaround field of the bank that was just read.
- R9: No turnaround cycles are inserted after a write, or between two reads to the same bank. The next access then starts chip select in the cycle right after acceptance.
- R10: Each bank's fields sit at bit offset b×width in the flattened configuration ports (width 4 for delays and turnaround, 5 for waits). Banks use their own values independently, including the extremes 0 and 15 for delays and 31 for waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid; held until `done` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Target bank number |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | NL | Write byte mask, one bit per lane |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid while `done` of a read |
| cfg_oe_dly | input | NBANK*4 | Per-bank chip-select-to-output-enable delay |
| cfg_rd_wait | input | NBANK*5 | Per-bank read wait (field+1 cycles) |
| cfg_we_dly | input | NBANK*4 | Per-bank extra write-enable delay |
| cfg_wr_wait | input | NBANK*5 | Per-bank write wait (field+1 cycles) |
| cfg_turn | input | NBANK*4 | Per-bank turnaround (field+1 cycles) |
| mem_addr | output | AW | External address |
| mem_cs_n | output | NBANK | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bls_n | output | NL | Active-low byte-lane strobes |
| mem_dq_out | output | DW | Write data to the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | DW | Read data from the bus |

## Verification
A wrong state or a miscounted down-counter shows up at the pins on the next cycle. The strobes are decoded directly from the state register, so a bad state changes a chip-select or strobe length by at least one cycle, and that error is seen when the access's chip select rises. A stale last-read flag or a stale last bank number does not show during the access that corrupts it. It appears on the following request, as a turnaround gap that is present or absent against the rule, or that is one bank's length instead of another's. The bench therefore orders accesses so that every transition class is followed by an access that exposes it.

// File: rtl/stmem_pkg.sv
package stmem_pkg;
    localparam int DLY_W  = 4;
    localparam int WAIT_W = 5;
    localparam int TURN_W = 4;
    localparam int CNT_W  = (WAIT_W > DLY_W) ? WAIT_W : DLY_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_RSETUP = 3'd2,
        ST_RACT   = 3'd3,
        ST_WSETUP = 3'd4,
        ST_WACT   = 3'd5,
        ST_WEND   = 3'd6
    } seq_state_t;
endpackage

// File: rtl/stmem_bank_cfg.sv
module stmem_bank_cfg
    import stmem_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [BW-1:0]           sel,
    input  logic [NBANK*DLY_W-1:0]  cfg_oe_dly,
    input  logic [NBANK*WAIT_W-1:0] cfg_rd_wait,
    input  logic [NBANK*DLY_W-1:0]  cfg_we_dly,
    input  logic [NBANK*WAIT_W-1:0] cfg_wr_wait,
    input  logic [NBANK*TURN_W-1:0] cfg_turn,
    output logic [DLY_W-1:0]        f_oe,
    output logic [WAIT_W-1:0]       f_rd,
    output logic [DLY_W-1:0]        f_we,
    output logic [WAIT_W-1:0]       f_wr,
    output logic [TURN_W-1:0]       f_turn
);
    logic [DLY_W-1:0]  oe_a   [NBANK];
    logic [WAIT_W-1:0] rd_a   [NBANK];
    logic [DLY_W-1:0]  we_a   [NBANK];
    logic [WAIT_W-1:0] wr_a   [NBANK];
    logic [TURN_W-1:0] turn_a [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign oe_a[b]   = cfg_oe_dly[b*DLY_W +: DLY_W];
        assign rd_a[b]   = cfg_rd_wait[b*WAIT_W +: WAIT_W];
        assign we_a[b]   = cfg_we_dly[b*DLY_W +: DLY_W];
        assign wr_a[b]   = cfg_wr_wait[b*WAIT_W +: WAIT_W];
        assign turn_a[b] = cfg_turn[b*TURN_W +: TURN_W];
    end

    assign f_oe   = oe_a[sel];
    assign f_rd   = rd_a[sel];
    assign f_we   = we_a[sel];
    assign f_wr   = wr_a[sel];
    assign f_turn = turn_a[sel];
endmodule

// File: rtl/stmem_strobe.sv
module stmem_strobe
    import stmem_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int NL    = 2,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  seq_state_t       st,
    input  logic [BW-1:0]    bank,
    input  logic [NL-1:0]    be,
    output logic [NBANK-1:0] cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [NL-1:0]    bls_n,
    output logic             dq_oe
);
    logic cs_act, rd_strobe, wr_strobe, wr_phase;

    always_comb begin
        cs_act    = 1'b0;
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        wr_phase  = 1'b0;
        unique case (st)
            ST_IDLE, ST_TURN: ;
            ST_RSETUP: cs_act = 1'b1;
            ST_RACT: begin
                cs_act    = 1'b1;
                rd_strobe = 1'b1;
            end
            ST_WSETUP, ST_WEND: begin
                cs_act   = 1'b1;
                wr_phase = 1'b1;
            end
            ST_WACT: begin
                cs_act    = 1'b1;
                wr_phase  = 1'b1;
                wr_strobe = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign cs_n[b] = !(cs_act && (bank == BW'(b)));
    end

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign bls_n[i] = !(wr_strobe && be[i]);
    end

    assign oe_n  = !rd_strobe;
    assign we_n  = !wr_strobe;
    assign dq_oe = wr_phase;
endmodule

// File: rtl/stmem_seq.sv
module stmem_seq
    import stmem_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int NL = DW / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    req_wr,
    input  logic [BW-1:0]           req_bank,
    input  logic [AW-1:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    input  logic [NL-1:0]           req_be,
    output logic                    done,
    output logic [DW-1:0]           rdata,
    input  logic [NBANK*DLY_W-1:0]  cfg_oe_dly,
    input  logic [NBANK*WAIT_W-1:0] cfg_rd_wait,
    input  logic [NBANK*DLY_W-1:0]  cfg_we_dly,
    input  logic [NBANK*WAIT_W-1:0] cfg_wr_wait,
    input  logic [NBANK*TURN_W-1:0] cfg_turn,
    output logic [AW-1:0]           mem_addr,
    output logic [NBANK-1:0]        mem_cs_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [NL-1:0]           mem_bls_n,
    output logic [DW-1:0]           mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DW-1:0]           mem_dq_in
);
    seq_state_t        st_q, st_d, st_start;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_start;
    logic              latch;
    logic              cur_wr;
    logic [BW-1:0]     cur_bank, last_bank, sel_bank;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [NL-1:0]     be_q;
    logic              last_rd;
    logic [TURN_W-1:0] turn_q;
    logic              need_turn, go_wr;
    logic [DLY_W-1:0]  f_oe, f_we;
    logic [WAIT_W-1:0] f_rd, f_wr;
    logic [TURN_W-1:0] f_turn;

    // In idle the incoming request picks the timing; afterwards the latched one
    assign sel_bank = (st_q == ST_IDLE) ? req_bank : cur_bank;
    assign go_wr    = (st_q == ST_IDLE) ? req_wr   : cur_wr;

    stmem_bank_cfg #(.NBANK(NBANK)) u_cfg (
        .sel         (sel_bank),
        .cfg_oe_dly  (cfg_oe_dly),
        .cfg_rd_wait (cfg_rd_wait),
        .cfg_we_dly  (cfg_we_dly),
        .cfg_wr_wait (cfg_wr_wait),
        .cfg_turn    (cfg_turn),
        .f_oe        (f_oe),
        .f_rd        (f_rd),
        .f_we        (f_we),
        .f_wr        (f_wr),
        .f_turn      (f_turn)
    );

    // A read leaves the bus owed a gap before a write or another bank
    assign need_turn = last_rd && (req_wr || (req_bank != last_bank));

    // First timed state of an access and its counter load
    always_comb begin
        if (go_wr) begin
            st_start  = ST_WSETUP;
            cnt_start = CNT_W'(f_we);
        end else if (f_oe != '0) begin
            st_start  = ST_RSETUP;
            cnt_start = CNT_W'(f_oe) - CNT_W'(1);
        end else begin
            st_start  = ST_RACT;
            cnt_start = CNT_W'(f_rd);
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        latch = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    latch = 1'b1;
                    if (need_turn) begin
                        st_d  = ST_TURN;
                        cnt_d = CNT_W'(turn_q);
                    end else begin
                        st_d  = st_start;
                        cnt_d = cnt_start;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_q == '0) begin
                    st_d  = st_start;
                    cnt_d = cnt_start;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RSETUP: begin
                if (cnt_q == '0) begin
                    st_d  = ST_RACT;
                    cnt_d = CNT_W'(f_rd);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RACT: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            ST_WSETUP: begin
                if (cnt_q == '0) begin
                    st_d  = ST_WACT;
                    cnt_d = CNT_W'(f_wr);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_WACT: begin
                if (cnt_q == '0) st_d = ST_WEND;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            ST_WEND: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign done = ((st_q == ST_RACT) && (cnt_q == '0)) || (st_q == ST_WEND);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Request capture and read-history tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_wr    <= 1'b0;
            cur_bank  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            last_rd   <= 1'b0;
            last_bank <= '0;
            turn_q    <= '0;
        end else begin
            if (latch) begin
                cur_wr   <= req_wr;
                cur_bank <= req_bank;
                addr_q   <= req_addr;
                wdata_q  <= req_wdata;
                be_q     <= req_be;
            end
            if (done) begin
                last_rd   <= !cur_wr;
                last_bank <= cur_bank;
                turn_q    <= f_turn;
            end
        end
    end

    stmem_strobe #(.NBANK(NBANK), .NL(NL)) u_strobe (
        .st    (st_q),
        .bank  (cur_bank),
        .be    (be_q),
        .cs_n  (mem_cs_n),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .bls_n (mem_bls_n),
        .dq_oe (mem_dq_oe)
    );

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rdata      = mem_dq_in;
endmodule

// File: rtl/stmem_seq_chk.sv
module stmem_seq_chk #(
    parameter int NBANK = 4,
    parameter int NL    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [NBANK-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [NL-1:0]    mem_bls_n,
    input logic             mem_dq_oe
);
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R3
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !(&mem_cs_n));

    // R3
    oe_release_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (&mem_cs_n));

    // R5
    we_release_before_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !(&mem_cs_n));

    // R5
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R6
    bls_within_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n |-> (&mem_bls_n));

    // R7
    dq_not_during_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R7
    dq_during_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R4
    done_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(&mem_cs_n));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind stmem_seq stmem_seq_chk #(.NBANK(NBANK), .NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bls_n (mem_bls_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/stmem_seq_bench.sv
module stmem_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBANK = 4;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int BW    = 2;
    localparam int NL    = DW / 8;

    typedef struct {
        int wr;
        int bank;
        int cs_len;
        int lead;
        int str_len;
        int gap;
        int be;
        int rdata;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic req_wr = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NL-1:0] req_be = '0;
    logic done;
    logic [DW-1:0] rdata;
    logic [NBANK*4-1:0] cfg_oe_dly, cfg_we_dly, cfg_turn;
    logic [NBANK*5-1:0] cfg_rd_wait, cfg_wr_wait;
    logic [AW-1:0] mem_addr;
    logic [NBANK-1:0] mem_cs_n;
    logic mem_oe_n, mem_we_n, mem_dq_oe;
    logic [NL-1:0] mem_bls_n;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    // per-bank timing held by the bench: {oe, rd, we, wr, turn}
    int oe_t[NBANK]   = '{0, 2, 15, 1};
    int rd_t[NBANK]   = '{0, 2, 31, 5};
    int we_t[NBANK]   = '{0, 2, 15, 3};
    int wr_t[NBANK]   = '{0, 2, 31, 0};
    int turn_t[NBANK] = '{0, 1, 15, 3};

    int checks = 0;
    int errors = 0;
    item_t exp_q[$];
    logic [DW-1:0] mem [64];
    logic [DW-1:0] shadow [64];
    int prev_rd = 0;
    int prev_bank = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            cfg_oe_dly[b*4 +: 4]  = 4'(oe_t[b]);
            cfg_rd_wait[b*5 +: 5] = 5'(rd_t[b]);
            cfg_we_dly[b*4 +: 4]  = 4'(we_t[b]);
            cfg_wr_wait[b*5 +: 5] = 5'(wr_t[b]);
            cfg_turn[b*4 +: 4]    = 4'(turn_t[b]);
        end
    end

    stmem_seq #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_stmem_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .done(done), .rdata(rdata),
        .cfg_oe_dly(cfg_oe_dly), .cfg_rd_wait(cfg_rd_wait),
        .cfg_we_dly(cfg_we_dly), .cfg_wr_wait(cfg_wr_wait),
        .cfg_turn(cfg_turn), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bls_n(mem_bls_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic int cs_index(input logic [NBANK-1:0] cs);
        int r = 0;
        for (int b = 0; b < NBANK; b++) if (!cs[b]) r = b;
        return r;
    endfunction

    assign mem_dq_in = (!mem_oe_n && (mem_cs_n != '1))
                     ? mem[{2'(cs_index(mem_cs_n)), mem_addr[3:0]}] : '0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Driver: push expectation, present request, wait for done
    task automatic access(input int wr, input int bank, input int addr,
                          input int data, input int be);
        item_t it;
        int idx = bank * 16 + (addr & 15);
        it.wr      = wr;
        it.bank    = bank;
        it.be      = be;
        it.lead    = wr ? we_t[bank] + 1 : oe_t[bank];
        it.str_len = wr ? wr_t[bank] + 1 : rd_t[bank] + 1;
        it.cs_len  = wr ? we_t[bank] + wr_t[bank] + 3 : oe_t[bank] + rd_t[bank] + 1;
        it.gap     = (prev_rd && (wr || bank != prev_bank)) ? turn_t[prev_bank] + 1 : 0;
        it.rdata   = int'(shadow[idx]);
        if (wr) begin
            for (int i = 0; i < NL; i++)
                if (be[i]) shadow[idx][i*8 +: 8] = 8'(data >> (8*i));
        end
        prev_rd   = !wr;
        prev_bank = bank;
        exp_q.push_back(it);
        @(negedge clk);
        req       = 1'b1;
        req_wr    = wr[0];
        req_bank  = BW'(bank);
        req_addr  = AW'(addr);
        req_wdata = DW'(data);
        req_be    = NL'(be);
        do @(negedge clk); while (!done);
        req = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: measures each access at the pins and compares to the queue head
    initial begin
        int in_acc = 0, cs_cnt = 0, lead = 0, str_cnt = 0, seen = 0;
        int gap = 0, bank_seen = 0, done_cnt = 0, rd_got = 0;
        int bls_bad = 0, dq_bad = 0;
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n) continue;
            if (mem_cs_n != '1) begin
                if (!in_acc) begin
                    in_acc = 1; cs_cnt = 0; lead = 0; str_cnt = 0; seen = 0;
                    done_cnt = 0; rd_got = 0; bls_bad = 0;
                    bank_seen = cs_index(mem_cs_n);
                end
                it = exp_q[0];
                cs_cnt++;
                if (!mem_oe_n || !mem_we_n) begin
                    seen = 1;
                    str_cnt++;
                end else if (!seen) begin
                    lead++;
                end
                if (mem_bls_n != (mem_we_n ? NL'('1) : ~NL'(it.be))) bls_bad = 1;
                if (mem_dq_oe != (it.wr != 0)) dq_bad = 1;
                if (!mem_we_n)
                    for (int i = 0; i < NL; i++)
                        if (!mem_bls_n[i])
                            mem[{2'(bank_seen), mem_addr[3:0]}][i*8 +: 8] = mem_dq_out[i*8 +: 8];
                if (done) begin
                    done_cnt++;
                    rd_got = int'(rdata);
                end
            end else begin
                if (mem_dq_oe || done) dq_bad = 1;
                if (in_acc) begin
                    it = exp_q.pop_front();
                    in_acc = 0;
                    chk("R2 bank select", bank_seen, it.bank);
                    chk("R10 per-bank cs length", cs_cnt, it.cs_len);
                    if (it.wr) begin
                        chk("R5 write enable lead", lead, it.lead);
                        chk("R5 write enable length", str_cnt, it.str_len);
                    end else begin
                        chk("R3 output enable lead", lead, it.lead);
                        chk("R3 output enable length", str_cnt, it.str_len);
                        chk("R4 read data", rd_got, it.rdata);
                    end
                    chk("R4 done pulses", done_cnt, 1);
                    chk("R6 byte lanes", bls_bad, 0);
                    chk("R7 data enable", dq_bad, 0);
                    dq_bad = 0;
                    if (it.gap != 0) chk("R8 turnaround", gap, it.gap);
                    else             chk("R9 no turnaround", gap, 0);
                    gap = 0;
                end else if (req) begin
                    gap++;
                end
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = DW'(i * 257) ^ 16'hA5C3;
            shadow[i] = DW'(i * 257) ^ 16'hA5C3;
        end
        repeat (3) @(negedge clk);
        // R1: idle outputs while and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs idle", int'(mem_cs_n), int'({NBANK{1'b1}}));
        chk("R1 oe idle", int'(mem_oe_n), 1);
        chk("R1 we idle", int'(mem_we_n), 1);
        chk("R1 bls idle", int'(mem_bls_n), int'({NL{1'b1}}));
        chk("R1 dq idle", int'(mem_dq_oe), 0);
        chk("R1 done idle", int'(done), 0);

        access(1, 0, 1, 16'h1111, 3);   // first write
        access(1, 0, 2, 16'h2222, 3);   // write->write, R9
        access(0, 0, 1, 0, 0);          // write->read, R9
        access(0, 0, 2, 0, 0);          // read->read same bank, R9
        access(0, 1, 5, 0, 0);          // read->read other bank, R8
        access(1, 1, 5, 16'hABCD, 1);   // read->write same bank, R8, R6
        access(0, 1, 5, 0, 0);          // merged lanes
        access(1, 2, 3, 16'h5A7E, 2);   // read->write other bank, R10 extremes
        access(0, 2, 3, 0, 0);
        access(0, 3, 7, 0, 0);          // turnaround of 16 cycles
        access(1, 3, 7, 16'hC0DE, 3);
        access(0, 3, 7, 0, 0);
        access(0, 0, 1, 0, 0);

        repeat (5) @(negedge clk);
        chk("R4 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule